// File: doc/BRIEF.md
# Instanced Attribute Index Generator

This block turns the flat index of a dispatched thread into the element index that an attribute fetch should use. Each request carries its own addressing mode. The index can pass through unchanged. It can be reduced modulo a padded vertex count of the form (odd) times (power of two). It can be divided by a power of two with a plain right shift. It can also be divided by an arbitrary integer, using a precomputed reciprocal multiplier. Software derives the multiplier, shift and correction flag. The block only applies them.

The unit is fully pipelined. It accepts one request every clock cycle, and every mode returns its result with the same latency. This keeps results in request order with no reordering logic. There is no back-pressure, so the consumer must take a result in the cycle `out_valid` is high. An unknown mode, or an odd factor out of range in modulo mode, gives a zero index with an error flag.

Top module: `attr_index_gen`

## Requirements
- R1: A request presented with `in_valid` high is sampled on a rising edge. Its result appears with `out_valid` high after the third rising edge, counting the sampling edge. A new request may be accepted on every edge, and results leave in request order.
- R2: Mode code 1 (pass-through) returns the input index unchanged, with no error.
- R3: Mode code 3 (modulo) returns index mod ((2·f+1)·2^s), where f is `in_extra` (0 to 4) and s is `in_shift`. This includes divisors that exceed 2^32, which leave the index unchanged.
- R4: Mode code 2 (shift divide) returns the index shifted right by `in_shift`. `in_extra` and `in_magic` are ignored.
- R5: Mode code 4 (reciprocal divide) uses multiplier M = `in_magic` with bit 31 forced to 1. It returns the upper 32 bits of the 64-bit product of the index and M, shifted right by `in_shift`. The index is not shifted before the multiply.
- R6: In mode code 4 with `in_extra` equal to 1, the index is replaced by index+1 before the multiply. The increment is computed at full precision, so index 0xFFFFFFFF with the divide-by-3 constants returns 0x55555555.
- R7: In mode code 4, with constants derived for a non-power-of-two divisor d, the result equals floor(index/d) for any 32-bit index. The constants are: shift s = floor(log2 d), then either ceil(2^(s+32)/d) with flag 0, or that value minus one with flag 1 when 2^(s+32) mod d ≤ 2^s.
- R8: Mode code 0 (unused) returns index 0 with no error, whatever the other inputs are.
- R9: Mode codes 5, 6 and 7, and mode code 3 with `in_extra` above 4, return index 0 with `out_err` high. `out_err` is never high while `out_valid` is low.
- R10: While `rst` is high, and on the first cycle after it falls, `out_valid`, `out_err` and `out_index` are 0. Requests presented during reset produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_index | input | 32 | Linear thread index |
| in_mode | input | 3 | Addressing mode code |
| in_shift | input | 5 | Power-of-two exponent or post-multiply shift |
| in_extra | input | 3 | Odd factor selector (modulo) or round-down flag (reciprocal) |
| in_magic | input | 32 | Reciprocal multiplier; bit 31 is ignored and treated as 1 |
| out_valid | output | 1 | Result present this cycle |
| out_index | output | 32 | Element index result, 0 when no result |
| out_err | output | 1 | Request had an undefined mode or odd factor |

## Verification
The properties take for granted that every request field is a known value whenever `in_valid` is high. They also assume the consumer takes every result, since nothing can stall the pipeline. They do not assume the reciprocal constants are correct: the divide-by-d property R7 holds only for well-formed constants, so it is checked by the stimulus and not by a property. The stimulus derives every multiplier, shift and flag from the divisor by the rule in R7. It skips powers of two, for which that rule does not apply. It keeps all other fields of a request defined, even the ones its mode ignores.

// File: rtl/attr_idx_pkg.sv
package attr_idx_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    AM_UNUSED   = 3'd0,
    AM_LINEAR   = 3'd1,
    AM_POT_DIV  = 3'd2,
    AM_MODULO   = 3'd3,
    AM_NPOT_DIV = 3'd4
  } attr_mode_e;

  // highest legal odd-factor selector: divisor odd part = 2*sel+1 up to 9
  localparam int ODD_SEL_MAX = 4;

endpackage

// File: rtl/attr_odd_mod.sv
// Modulo by (2*sel+1) * 2^shift, split as: low bits pass, high part mod odd.
module attr_odd_mod #(
  parameter int IDX_W   = 32,
  parameter int SHIFT_W = 5,
  parameter int SEL_W   = 3
) (
  input  logic [IDX_W-1:0]   idx,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [SEL_W-1:0]   sel,
  output logic [IDX_W-1:0]   res
);
  import attr_idx_pkg::*;

  localparam int NODD  = ODD_SEL_MAX + 1;
  localparam int REM_W = $clog2(2 * ODD_SEL_MAX + 1);

  logic [IDX_W-1:0] hi_part;
  logic [IDX_W-1:0] lo_mask;
  logic [REM_W-1:0] rems [NODD];
  logic [REM_W-1:0] rem_sel;

  assign hi_part = idx >> shift;
  assign lo_mask = ~({IDX_W{1'b1}} << shift);

  generate
    for (genvar k = 0; k < NODD; k++) begin : g_odd
      localparam logic [IDX_W-1:0] ODD_F = IDX_W'(2 * k + 1);
      logic [IDX_W-1:0] full_rem;
      assign full_rem = hi_part % ODD_F;
      assign rems[k]  = full_rem[REM_W-1:0];
    end
  endgenerate

  always_comb begin
    rem_sel = '0;
    for (int k = 0; k < NODD; k++) begin
      if (sel == SEL_W'(k)) rem_sel = rems[k];
    end
  end

  assign res = (IDX_W'(rem_sel) << shift) | (idx & lo_mask);

endmodule

// File: rtl/attr_magic_mul.sv
// Registered high half of a*b (+b when add_b): high half of (a+add_b)*b.
module attr_magic_mul #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         add_b,
  output logic [W-1:0] hi
);
  localparam int PW = 2 * W;

  logic [PW-1:0] prod;
  logic [PW-1:0] addend;
  logic [W-1:0]  hi_next;
  logic [W-1:0]  lo_unused;

  assign prod    = {{W{1'b0}}, a} * {{W{1'b0}}, b};
  assign addend  = add_b ? {{W{1'b0}}, b} : '0;
  // (a+1)*b < 2^PW because b < 2^W, so the sum never wraps
  assign {hi_next, lo_unused} = prod + addend;

  always_ff @(posedge clk) begin
    hi <= hi_next;
  end

endmodule

// File: rtl/attr_index_gen.sv
module attr_index_gen
  import attr_idx_pkg::*;
#(
  parameter int IDX_W   = 32,
  parameter int SHIFT_W = 5,
  parameter int EXTRA_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [IDX_W-1:0]   in_index,
  input  logic [MODE_W-1:0]  in_mode,
  input  logic [SHIFT_W-1:0] in_shift,
  input  logic [EXTRA_W-1:0] in_extra,
  input  logic [IDX_W-1:0]   in_magic,
  output logic               out_valid,
  output logic [IDX_W-1:0]   out_index,
  output logic               out_err
);

  localparam logic [IDX_W-1:0]   TOP_BIT   = IDX_W'(1) << (IDX_W - 1);
  localparam logic [EXTRA_W-1:0] SEL_LIMIT = EXTRA_W'(ODD_SEL_MAX);
  localparam logic [EXTRA_W-1:0] RD_CODE   = EXTRA_W'(1);

  // ---------------- stage 1: capture and classify ----------------
  logic               s1_valid;
  logic [MODE_W-1:0]  s1_mode;
  logic [IDX_W-1:0]   s1_idx;
  logic [SHIFT_W-1:0] s1_shift;
  logic [EXTRA_W-1:0] s1_extra;
  logic [IDX_W-1:0]   s1_mag;
  logic               s1_rd;
  logic               s1_err;
  logic               in_bad;

  assign in_bad = (in_mode > MODE_W'(AM_NPOT_DIV)) ||
                  ((in_mode == MODE_W'(AM_MODULO)) && (in_extra > SEL_LIMIT));

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
    s1_mode  <= in_mode;
    s1_idx   <= in_index;
    s1_shift <= in_shift;
    s1_extra <= in_extra;
    s1_mag   <= in_magic | TOP_BIT;
    s1_rd    <= (in_mode == MODE_W'(AM_NPOT_DIV)) && (in_extra == RD_CODE);
    s1_err   <= in_bad;
  end

  // ---------------- stage 2: multiply and simple modes ----------------
  logic [IDX_W-1:0]   mul_hi;
  logic [IDX_W-1:0]   mod_res;
  logic [IDX_W-1:0]   alt_res;
  logic               s2_valid;
  logic               s2_npot;
  logic               s2_err;
  logic [SHIFT_W-1:0] s2_shift;
  logic [IDX_W-1:0]   s2_alt;

  attr_magic_mul #(.W(IDX_W)) u_mul (
    .clk   (clk),
    .a     (s1_idx),
    .b     (s1_mag),
    .add_b (s1_rd),
    .hi    (mul_hi)
  );

  attr_odd_mod #(
    .IDX_W   (IDX_W),
    .SHIFT_W (SHIFT_W),
    .SEL_W   (EXTRA_W)
  ) u_mod (
    .idx   (s1_idx),
    .shift (s1_shift),
    .sel   (s1_extra),
    .res   (mod_res)
  );

  always_comb begin
    alt_res = '0;
    if (!s1_err) begin
      unique case (s1_mode)
        MODE_W'(AM_LINEAR):  alt_res = s1_idx;
        MODE_W'(AM_POT_DIV): alt_res = s1_idx >> s1_shift;
        MODE_W'(AM_MODULO):  alt_res = mod_res;
        default:             alt_res = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) s2_valid <= 1'b0;
    else     s2_valid <= s1_valid;
    s2_npot  <= (s1_mode == MODE_W'(AM_NPOT_DIV));
    s2_err   <= s1_err;
    s2_shift <= s1_shift;
    s2_alt   <= alt_res;
  end

  // ---------------- stage 3: post-shift and output register ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_index <= '0;
    end else begin
      out_valid <= s2_valid;
      out_err   <= s2_valid & s2_err;
      if (!s2_valid)    out_index <= '0;
      else if (s2_npot) out_index <= mul_hi >> s2_shift;
      else              out_index <= s2_alt;
    end
  end

endmodule

// File: rtl/attr_index_gen_chk.sv
module attr_index_gen_chk #(
  parameter int IDX_W   = 32,
  parameter int SHIFT_W = 5,
  parameter int EXTRA_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [IDX_W-1:0]   in_index,
  input logic [2:0]         in_mode,
  input logic [SHIFT_W-1:0] in_shift,
  input logic [EXTRA_W-1:0] in_extra,
  input logic               out_valid,
  input logic [IDX_W-1:0]   out_index,
  input logic               out_err
);
  localparam int DW = 2 * IDX_W + 8;

  logic [1:0]    since_rst;
  logic          hist_ok;
  logic [DW-1:0] mod_div;

  always_ff @(posedge clk) begin
    if (rst)                    since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end
  assign hist_ok = (since_rst == 2'd3);
  assign mod_div = DW'(2 * in_extra + 1) << in_shift;

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    hist_ok |-> (out_valid == $past(in_valid, 3))); // R1

  AST_LINEAR_PASS: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && out_valid && $past(in_mode, 3) == 3'd1)
      |-> (out_index == $past(in_index, 3) && !out_err)); // R2

  AST_MODULO_BOUND: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && out_valid && $past(in_mode, 3) == 3'd3 && $past(in_extra, 3) <= 3'd4)
      |-> (DW'(out_index) < $past(mod_div, 3) && !out_err)); // R3

  AST_SHIFT_DIVIDE: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && out_valid && $past(in_mode, 3) == 3'd2)
      |-> (out_index == ($past(in_index, 3) >> $past(in_shift, 3)))); // R4

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && out_valid && $past(in_mode, 3) == 3'd0)
      |-> (out_index == '0 && !out_err)); // R8

  AST_BAD_MODE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && out_valid && $past(in_mode, 3) > 3'd4)
      |-> (out_err && out_index == '0)); // R9

  AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !out_err); // R9

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_err && out_index == '0)); // R10

endmodule

bind attr_index_gen attr_index_gen_chk #(
  .IDX_W   (IDX_W),
  .SHIFT_W (SHIFT_W),
  .EXTRA_W (EXTRA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_index  (in_index),
  .in_mode   (in_mode),
  .in_shift  (in_shift),
  .in_extra  (in_extra),
  .out_valid (out_valid),
  .out_index (out_index),
  .out_err   (out_err)
);

// File: tb/attr_index_gen_bench.sv
module attr_index_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_index = '0;
  logic [2:0]  in_mode = '0;
  logic [4:0]  in_shift = '0;
  logic [2:0]  in_extra = '0;
  logic [31:0] in_magic = '0;
  logic        out_valid;
  logic [31:0] out_index;
  logic        out_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] val;
    logic        err;
    string       req;
    int          t0;
  } exp_t;

  exp_t sbq[$];
  exp_t mon_it;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  attr_index_gen u_attr_index_gen (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_index  (in_index),
    .in_mode   (in_mode),
    .in_shift  (in_shift),
    .in_extra  (in_extra),
    .in_magic  (in_magic),
    .out_valid (out_valid),
    .out_index (out_index),
    .out_err   (out_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // driver: one request per call, back to back when called consecutively
  task automatic send(input logic [31:0] idx, input logic [2:0] mode,
                      input logic [4:0] sh, input logic [2:0] ex,
                      input logic [31:0] mg, input logic [31:0] ev,
                      input logic ee, input string req);
    exp_t it;
    @(negedge clk);
    in_valid = 1'b1;
    in_index = idx;
    in_mode  = mode;
    in_shift = sh;
    in_extra = ex;
    in_magic = mg;
    it.val = ev;
    it.err = ee;
    it.req = req;
    it.t0  = cyc;
    sbq.push_back(it);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_index = '0;
      in_mode  = '0;
      in_shift = '0;
      in_extra = '0;
      in_magic = '0;
    end
  endtask

  // monitor: compares each result with the oldest expected item
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R1", "result without request", out_index, 32'h0);
      end else begin
        mon_it = sbq.pop_front();
        chk(out_index === mon_it.val && out_err === mon_it.err, mon_it.req,
            "index/err", {out_index[30:0], out_err}, {mon_it.val[30:0], mon_it.err});
        chk(cyc - mon_it.t0 == 3, "R1", "latency",
            32'(cyc - mon_it.t0), 32'd3);
      end
    end
  end

  // reciprocal constants per R7
  task automatic magic_for(input longint unsigned d, output logic [4:0] s,
                           output logic [31:0] m, output logic rd);
    longint unsigned p;
    longint unsigned q;
    longint unsigned e;
    longint unsigned mc;
    int k;
    k = 0;
    while ((64'd1 << (k + 1)) <= d) k++;
    p  = 64'd1 << (k + 32);
    q  = p / d;
    e  = p % d;
    mc = (e == 0) ? q : q + 1;
    s  = 5'(k);
    if (e <= (64'd1 << k)) begin
      m  = 32'(mc - 1);
      rd = 1'b1;
    end else begin
      m  = 32'(mc);
      rd = 1'b0;
    end
  endtask

  function automatic logic [31:0] recip_model(input logic [31:0] idx,
      input logic [31:0] mg, input logic [4:0] sh, input logic rd);
    longint unsigned mm;
    longint unsigned n;
    mm = 64'(mg | 32'h8000_0000);
    n  = 64'(idx) + (rd ? 64'd1 : 64'd0);
    return 32'(((n * mm) >> 32) >> sh);
  endfunction

  function automatic logic [31:0] mod_model(input logic [31:0] idx,
      input logic [4:0] sh, input logic [2:0] ex);
    longint unsigned dv;
    dv = (64'(2 * ex + 1)) << sh;
    return 32'(64'(idx) % dv);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int dl[8] = '{3, 5, 7, 11, 72, 100, 1000, 12345};
    logic [4:0]  s;
    logic [31:0] m;
    logic        rd;
    logic [31:0] ix;

    // R10: requests during reset are dropped, outputs stay clear
    in_valid = 1'b1;
    in_mode  = 3'd1;
    in_index = 32'hDEAD_BEEF;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R10", "out_valid after reset", 32'(out_valid), 32'h0);
    chk(out_err == 1'b0, "R10", "out_err after reset", 32'(out_err), 32'h0);
    chk(out_index == 32'h0, "R10", "out_index after reset", out_index, 32'h0);
    idle(4);
    chk(sbq.size() == 0 && out_valid == 1'b0, "R10", "no result from reset-time request",
        32'(out_valid), 32'h0);

    // R8: unused mode ignores all other fields
    send(32'h1234_5678, 3'd0, 5'd7, 3'd2, 32'hFFFF_FFFF, 32'h0, 1'b0, "R8");
    send(32'hFFFF_FFFF, 3'd0, 5'd0, 3'd1, 32'h0, 32'h0, 1'b0, "R8");

    // R2: pass-through
    send(32'h0000_0000, 3'd1, 5'd3, 3'd4, 32'h1, 32'h0000_0000, 1'b0, "R2");
    send(32'hCAFE_F00D, 3'd1, 5'd31, 3'd7, 32'h5, 32'hCAFE_F00D, 1'b0, "R2");
    send(32'hFFFF_FFFF, 3'd1, 5'd0, 3'd0, 32'h0, 32'hFFFF_FFFF, 1'b0, "R2");

    // R4: shift divide, extra and magic ignored
    send(32'hF000_0001, 3'd2, 5'd0, 3'd5, 32'h9, 32'hF000_0001, 1'b0, "R4");
    send(32'hF000_0001, 3'd2, 5'd5, 3'd1, 32'h0, 32'h0780_0000, 1'b0, "R4");
    send(32'hF000_0001, 3'd2, 5'd31, 3'd0, 32'h0, 32'h0000_0001, 1'b0, "R4");

    // R3: modulo, every odd factor, boundaries and oversize divisor
    send(32'd70, 3'd3, 5'd3, 3'd4, 32'h0, 32'd70, 1'b0, "R3");
    send(32'd1000, 3'd3, 5'd3, 3'd4, 32'h0, 32'd64, 1'b0, "R3");
    send(32'd72, 3'd3, 5'd3, 3'd4, 32'h0, 32'd0, 1'b0, "R3");
    send(32'hFFFF_FFFF, 3'd3, 5'd31, 3'd4, 32'h0, 32'hFFFF_FFFF, 1'b0, "R3");
    for (int e = 0; e <= 4; e++) begin
      for (int k = 0; k < 3; k++) begin
        logic [4:0] sh;
        ix = $urandom;
        sh = 5'($urandom_range(0, 31));
        send(ix, 3'd3, sh, 3'(e), 32'h0, mod_model(ix, sh, 3'(e)), 1'b0, "R3");
      end
    end

    // R9: undefined modes and out-of-range odd factor
    send(32'h0000_0055, 3'd5, 5'd1, 3'd0, 32'h0, 32'h0, 1'b1, "R9");
    send(32'h0000_0055, 3'd6, 5'd1, 3'd0, 32'h0, 32'h0, 1'b1, "R9");
    send(32'h0000_0055, 3'd7, 5'd1, 3'd0, 32'h0, 32'h0, 1'b1, "R9");
    send(32'h0000_0055, 3'd3, 5'd1, 3'd5, 32'h0, 32'h0, 1'b1, "R9");
    send(32'h0000_0055, 3'd3, 5'd0, 3'd7, 32'h0, 32'h0, 1'b1, "R9");

    // R5: raw multiplier with bit 31 forced
    send(32'h1234_5678, 3'd4, 5'd0, 3'd0, 32'h0000_0000, 32'h091A_2B3C, 1'b0, "R5");
    send(32'h1234_5678, 3'd4, 5'd0, 3'd0, 32'h8000_0000, 32'h091A_2B3C, 1'b0, "R5");
    send(32'hFFFF_FFFF, 3'd4, 5'd2, 3'd0, 32'h0000_1234,
         recip_model(32'hFFFF_FFFF, 32'h0000_1234, 5'd2, 1'b0), 1'b0, "R5");
    send(32'hABCD_0123, 3'd4, 5'd0, 3'd2, 32'h7FFF_FFFF,
         recip_model(32'hABCD_0123, 32'h7FFF_FFFF, 5'd0, 1'b0), 1'b0, "R5");

    // R6: round-down increment at full precision
    send(32'd5, 3'd4, 5'd0, 3'd1, 32'h0, 32'd3, 1'b0, "R6");
    magic_for(64'd3, s, m, rd);
    send(32'hFFFF_FFFF, 3'd4, s, {2'b00, rd}, m & 32'h7FFF_FFFF,
         32'h5555_5555, 1'b0, "R6");

    // R7: true division with derived constants, back to back
    for (int j = 0; j < 14; j++) begin
      longint unsigned d;
      if (j < 8) d = 64'(dl[j]);
      else begin
        d = 64'($urandom_range(3, 1 << 24));
        if ((d & (d - 1)) == 0) d = d + 1;
      end
      magic_for(d, s, m, rd);
      for (int k = 0; k < 6; k++) begin
        case (k)
          0: ix = 32'h0;
          1: ix = 32'(d - 1);
          2: ix = 32'(d);
          5: ix = 32'hFFFF_FFFF;
          default: ix = $urandom;
        endcase
        send(ix, 3'd4, s, {2'b00, rd}, m & 32'h7FFF_FFFF,
             32'(64'(ix) / d), 1'b0, "R7");
      end
    end

    idle(6);
    chk(sbq.size() == 0, "R1", "all requests answered", 32'(sbq.size()), 32'h0);
    chk(out_valid == 1'b0 && out_err == 1'b0, "R9", "quiet when idle",
        {30'h0, out_valid, out_err}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule